// File: doc/BRIEF.md
# Indirect Counter Configuration Access Checker

This block holds the event-type configuration registers of a performance-monitor unit, one 32-bit register per implemented event counter, plus a single 32-bit filter register belonging to the cycle counter. Software never addresses these registers directly. A 5-bit selector names the target, and each read or write through the shared window reaches that target. A selector value of 31 names the cycle filter. Any value below the implemented counter count names that event register.

Each request arrives with the current privilege level (0 to 3) and a set of trap, enable and mask controls. The block passes these through a fixed priority chain of checks. The result is one outcome code: success, undefined, a trap to level 1, 2 or 3, read-as-zero, or write-ignored. Only a successful write changes a register. The response comes back one cycle after the request, with the outcome code and the read data.

Top module: `pmu_cfg_window`

## Requirements
- R1: A successful request returns outcome code 0 (OK). Selector 31 reaches the cycle filter register, and selector n below NCNT reaches event register n. A successful read returns that register's current value.
- R2: All registers reset to zero. A successful write updates the selected register on the clock edge that accepts the request, so a read in the very next cycle returns the new value.
- R3: If the selector is not 31 and is at or above NCNT, the outcome at every level is 1 (UNDEF) when FINE_TRAP=1. When FINE_TRAP=0 it is 5 (RAZ) for a read and 6 (WI) for a write.
- R4: At level 3, an in-range selector always gives OK.
- R5: At level 2, the outcome is UNDEF when both l3_pm_trap and l3_undef_first are set. It is 4 (TRAP_L3) when only l3_pm_trap is set, and OK otherwise.
- R6: At levels 0 and 1, setting both l3_pm_trap and l3_undef_first gives UNDEF ahead of every other check except R3.
- R7: At level 0, if user_en is clear and user_ext_en is not effective (EXT_USER=1 and bit set), the outcome is 2 (TRAP_L1). It becomes 3 (TRAP_L2) when host_redirect is set. This check comes right after R6.
- R8: At levels 0 and 1, when l2_enabled is set, the checks run in this order. First l2_group_trap, then l2_pm_trap, each giving TRAP_L2. Next, a selector other than 31 that is at or above l2_limit gives TRAP_L2 when FINE_TRAP=1, and RAZ/WI otherwise. After these, l3_pm_trap gives TRAP_L3. When l2_enabled is clear, all three level-2 checks are ignored.
- R9: At level 0 with user_ext_en effective, a read whose mask bit is clear returns RAZ with zero data. The mask bit is user_mask[sel], or user_mask_cyc for selector 31.
- R10: At level 0 with user_ext_en effective, a write is WI and changes no register when the mask bit is clear. It is also WI when the read-only bit is set: user_evt_ro for event registers, user_cyc_ro for selector 31.
- R11: rsp_valid is high exactly one cycle after req_valid. rsp_rdata is zero unless the response is a successful read. A non-OK outcome leaves every register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_level | input | 2 | Privilege level of the requester |
| req_sel | input | 5 | Selector; 31 = cycle filter |
| req_wdata | input | 32 | Write data |
| user_en | input | 1 | Level-0 access enable |
| user_ext_en | input | 1 | Extended level-0 enable with per-counter masking |
| user_evt_ro | input | 1 | Extended mode: event registers read-only at level 0 |
| user_cyc_ro | input | 1 | Extended mode: cycle filter read-only at level 0 |
| user_mask | input | NCNT | Per-counter level-0 access mask |
| user_mask_cyc | input | 1 | Level-0 access mask bit for the cycle filter |
| host_redirect | input | 1 | Redirect level-0 enable trap to level 2 |
| l2_enabled | input | 1 | Level 2 present and active |
| l2_group_trap | input | 1 | Level-2 trap on the register group |
| l2_pm_trap | input | 1 | Level-2 trap on monitor accesses |
| l2_limit | input | 5 | Counters accessible below level 2 |
| l3_pm_trap | input | 1 | Level-3 trap on monitor accesses |
| l3_undef_first | input | 1 | Level-3 trap reports as undefined with top priority |
| rsp_valid | output | 1 | Response present |
| rsp_code | output | 3 | Outcome: 0 OK, 1 UNDEF, 2 TRAP_L1, 3 TRAP_L2, 4 TRAP_L3, 5 RAZ, 6 WI |
| rsp_rdata | output | 32 | Read data |

## Verification
The register update from a successful write and the response of the next request share a clock edge. The bench provokes this by issuing a write and then a read of the same selector back to back, with no idle cycle between them. The read must return the freshly written value, not the old one. Random streams also mix masked or trapped writes with reads in adjacent cycles. The behavioural model is compared on every response to show that a refused write never leaks into the data returned next.

// File: rtl/pmu_cfg_window.sv
module pmu_cfg_window #(
  parameter int NCNT      = 6,
  parameter int W         = 32,
  parameter bit FINE_TRAP = 1'b1,
  parameter bit EXT_USER  = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic            req_write,
  input  logic [1:0]      req_level,
  input  logic [4:0]      req_sel,
  input  logic [W-1:0]    req_wdata,
  input  logic            user_en,
  input  logic            user_ext_en,
  input  logic            user_evt_ro,
  input  logic            user_cyc_ro,
  input  logic [NCNT-1:0] user_mask,
  input  logic            user_mask_cyc,
  input  logic            host_redirect,
  input  logic            l2_enabled,
  input  logic            l2_group_trap,
  input  logic            l2_pm_trap,
  input  logic [4:0]      l2_limit,
  input  logic            l3_pm_trap,
  input  logic            l3_undef_first,
  output logic            rsp_valid,
  output logic [2:0]      rsp_code,
  output logic [W-1:0]    rsp_rdata
);

  localparam logic [2:0] C_OK = 3'd0, C_UNDEF = 3'd1, C_TL1 = 3'd2, C_TL2 = 3'd3,
                         C_TL3 = 3'd4, C_RAZ = 3'd5, C_WI = 3'd6;
  localparam logic [5:0] CNT6 = 6'(NCNT);

  logic [W-1:0] evt_q [NCNT];
  logic [W-1:0] cyc_q;
  logic [W-1:0] sel_val;
  logic         mask_bit, ro_bit, is_cyc, beyond_impl, beyond_lim;
  logic         lockout, ext_on, user_ok;
  logic [2:0]   code;
  logic         commit;

  assign is_cyc      = (req_sel == 5'd31);
  assign beyond_impl = !is_cyc && ({1'b0, req_sel} >= CNT6);
  assign beyond_lim  = !is_cyc && (req_sel >= l2_limit);
  assign lockout     = l3_pm_trap && l3_undef_first;
  assign ext_on      = EXT_USER && user_ext_en;
  assign user_ok     = user_en || ext_on;
  assign ro_bit      = is_cyc ? user_cyc_ro : user_evt_ro;

  always_comb begin
    sel_val  = is_cyc ? cyc_q : '0;
    mask_bit = is_cyc ? user_mask_cyc : 1'b0;
    for (int i = 0; i < NCNT; i++) begin
      if (req_sel == 5'(i)) begin
        sel_val  = evt_q[i];
        mask_bit = user_mask[i];
      end
    end
  end

  always_comb begin
    code = C_OK;
    if (beyond_impl)
      code = FINE_TRAP ? C_UNDEF : (req_write ? C_WI : C_RAZ);
    else if (req_level == 2'd3)
      code = C_OK;
    else if (req_level == 2'd2)
      code = lockout ? C_UNDEF : (l3_pm_trap ? C_TL3 : C_OK);
    else if (lockout)
      code = C_UNDEF;
    else if (req_level == 2'd0 && !user_ok)
      code = host_redirect ? C_TL2 : C_TL1;
    else if (l2_enabled && (l2_group_trap || l2_pm_trap))
      code = C_TL2;
    else if (l2_enabled && beyond_lim)
      code = FINE_TRAP ? C_TL2 : (req_write ? C_WI : C_RAZ);
    else if (l3_pm_trap)
      code = C_TL3;
    else if (req_level == 2'd0 && ext_on) begin
      if (!req_write && !mask_bit)                code = C_RAZ;
      else if (req_write && (!mask_bit || ro_bit)) code = C_WI;
    end
  end

  assign commit = req_valid && req_write && (code == C_OK);

  for (genvar g = 0; g < NCNT; g++) begin : g_evt
    always_ff @(posedge clk) begin
      if (!rst_n)                              evt_q[g] <= '0;
      else if (commit && req_sel == 5'(g))     evt_q[g] <= req_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                cyc_q <= '0;
    else if (commit && is_cyc) cyc_q <= req_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_code  <= C_OK;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_code  <= req_valid ? code : C_OK;
      rsp_rdata <= (req_valid && !req_write && code == C_OK) ? sel_val : '0;
    end
  end

  assert_rsp_follows_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  assert_no_spurious_rsp_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  assert_rdata_zero_unless_ok_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_code != C_OK) |-> rsp_rdata == '0);
  assert_out_of_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !is_cyc && {1'b0, req_sel} >= CNT6) |=>
      rsp_code == (FINE_TRAP ? C_UNDEF : ($past(req_write) ? C_WI : C_RAZ)));
  assert_level3_passes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_level == 2'd3 && (is_cyc || {1'b0, req_sel} < CNT6)) |=> rsp_code == C_OK);
  assert_cyc_untouched_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_write && is_cyc) |=> $stable(cyc_q));

endmodule

// File: tb/tb_pmu_cfg_window.sv
module tb_pmu_cfg_window;
  localparam int N = 6;
  localparam logic [2:0] OK = 0, UNDEF = 1, TL1 = 2, TL2 = 3, TL3 = 4, RAZ = 5, WI = 6;

  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic req_valid = 0, req_write = 0;
  logic [1:0] req_level = 0;
  logic [4:0] req_sel = 0;
  logic [31:0] req_wdata = 0;
  logic user_en = 0, user_ext_en = 0, user_evt_ro = 0, user_cyc_ro = 0, user_mask_cyc = 0;
  logic [N-1:0] user_mask = 0;
  logic host_redirect = 0, l2_enabled = 0, l2_group_trap = 0, l2_pm_trap = 0;
  logic [4:0] l2_limit = 0;
  logic l3_pm_trap = 0, l3_undef_first = 0;
  logic rsp_valid, rsp_valid2;
  logic [2:0] rsp_code, rsp_code2;
  logic [31:0] rsp_rdata, rsp_rdata2;

  pmu_cfg_window #(.NCNT(N), .W(32), .FINE_TRAP(1'b1), .EXT_USER(1'b1)) dut (
    .clk, .rst_n, .req_valid, .req_write, .req_level, .req_sel, .req_wdata,
    .user_en, .user_ext_en, .user_evt_ro, .user_cyc_ro, .user_mask, .user_mask_cyc,
    .host_redirect, .l2_enabled, .l2_group_trap, .l2_pm_trap, .l2_limit,
    .l3_pm_trap, .l3_undef_first, .rsp_valid, .rsp_code, .rsp_rdata);

  pmu_cfg_window #(.NCNT(N), .W(32), .FINE_TRAP(1'b0), .EXT_USER(1'b1)) dut_nf (
    .clk, .rst_n, .req_valid, .req_write, .req_level, .req_sel, .req_wdata,
    .user_en, .user_ext_en, .user_evt_ro, .user_cyc_ro, .user_mask, .user_mask_cyc,
    .host_redirect, .l2_enabled, .l2_group_trap, .l2_pm_trap, .l2_limit,
    .l3_pm_trap, .l3_undef_first, .rsp_valid(rsp_valid2), .rsp_code(rsp_code2),
    .rsp_rdata(rsp_rdata2));

  int errors = 0, checks = 0;
  logic [31:0] m_evt [N];
  logic [31:0] m_cyc;
  string why;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h (sel=%0d lvl=%0d wr=%0b)",
               tag, act, exp, req_sel, req_level, req_write);
    end
  endtask

  function automatic logic [2:0] model(bit fine, bit w, int lvl, int sel);
    bit cyc = (sel == 31);
    bit mb, ro;
    if (!cyc && sel >= N) begin why = "R3"; return fine ? UNDEF : (w ? WI : RAZ); end
    if (lvl == 3) begin why = w ? "R2" : "R4"; return OK; end
    if (lvl == 2) begin
      why = "R5";
      if (l3_pm_trap && l3_undef_first) return UNDEF;
      if (l3_pm_trap) return TL3;
      return OK;
    end
    if (l3_pm_trap && l3_undef_first) begin why = "R6"; return UNDEF; end
    if (lvl == 0 && !user_en && !user_ext_en) begin why = "R7"; return host_redirect ? TL2 : TL1; end
    why = "R8";
    if (l2_enabled && l2_group_trap) return TL2;
    if (l2_enabled && l2_pm_trap) return TL2;
    if (l2_enabled && !cyc && sel >= l2_limit) return fine ? TL2 : (w ? WI : RAZ);
    if (l3_pm_trap) return TL3;
    if (lvl == 0 && user_ext_en) begin
      mb = cyc ? user_mask_cyc : user_mask[sel];
      ro = cyc ? user_cyc_ro : user_evt_ro;
      if (!w && !mb) begin why = "R9"; return RAZ; end
      if (w && (!mb || ro)) begin why = "R10"; return WI; end
    end
    why = w ? "R2" : "R1";
    return OK;
  endfunction

  task automatic req(bit w, int lvl, int sel, logic [31:0] d);
    logic [2:0] e, e2;
    logic [31:0] ed;
    req_valid = 1; req_write = w; req_level = 2'(lvl); req_sel = 5'(sel); req_wdata = d;
    e2 = model(1'b0, w, lvl, sel);
    e  = model(1'b1, w, lvl, sel);
    ed = 0;
    if (e == OK && !w) ed = (sel == 31) ? m_cyc : m_evt[sel];
    if (e == OK && w) begin
      if (sel == 31) m_cyc = d; else m_evt[sel] = d;
    end
    @(negedge clk);
    chk("R11 valid", {31'b0, rsp_valid}, 1);
    chk({why, " code"}, {29'b0, rsp_code}, {29'b0, e});
    chk({why, " rdata"}, rsp_rdata, ed);
    if (sel != 31 && sel >= N) chk("R3 no-fine code", {29'b0, rsp_code2}, {29'b0, e2});
    req_valid = 0;
  endtask

  task automatic idle();
    @(negedge clk);
    chk("R11 idle", {30'b0, rsp_valid, rsp_valid2}, 0);
  endtask

  task automatic clear_ctl();
    user_en = 0; user_ext_en = 0; user_evt_ro = 0; user_cyc_ro = 0; user_mask = 0;
    user_mask_cyc = 0; host_redirect = 0; l2_enabled = 0; l2_group_trap = 0;
    l2_pm_trap = 0; l2_limit = 0; l3_pm_trap = 0; l3_undef_first = 0;
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) m_evt[i] = 0;
    m_cyc = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle();
    for (int i = 0; i < N; i++) req(0, 3, i, 0);
    req(0, 3, 31, 0);
    for (int i = 0; i < N; i++) begin req(1, 3, i, 32'hA500_0000 + i); req(0, 3, i, 0); end
    req(1, 3, 31, 32'hC0DE_0031); req(0, 3, 31, 0);
    idle();
    for (int l = 0; l < 4; l++) begin req(0, l, N, 0); req(1, l, 30, 32'hDEAD); end
    req(0, 3, 0, 0);
    l3_pm_trap = 1; req(0, 2, 1, 0); l3_undef_first = 1; req(1, 2, 31, 32'h1);
    req(0, 1, 2, 0); req(1, 0, 2, 32'h2);
    clear_ctl(); req(0, 2, 3, 0);
    req(0, 0, 1, 0); host_redirect = 1; req(1, 0, 1, 32'h3);
    user_en = 1; req(0, 0, 1, 0);
    l2_enabled = 1; l2_limit = 3; req(0, 1, 3, 0); req(0, 0, 2, 0);
    l2_group_trap = 1; req(0, 1, 0, 0); l2_group_trap = 0; l2_pm_trap = 1; req(0, 0, 31, 0);
    l2_pm_trap = 0; l3_pm_trap = 1; req(0, 1, 0, 0);
    l2_enabled = 0; l2_group_trap = 1; l3_pm_trap = 0; req(0, 1, 4, 0);
    clear_ctl(); user_ext_en = 1; user_mask = 6'b000101;
    req(0, 0, 0, 0); req(0, 0, 1, 0); req(0, 0, 31, 0);
    req(1, 0, 1, 32'hBAD1); req(0, 3, 1, 0);
    user_evt_ro = 1; req(1, 0, 0, 32'hBAD0); req(0, 3, 0, 0);
    user_evt_ro = 0; req(1, 0, 2, 32'h600D); req(0, 3, 2, 0);
    user_mask_cyc = 1; user_cyc_ro = 1; req(1, 0, 31, 32'hBAD3); req(0, 3, 31, 0);
    idle();
    for (int k = 0; k < 3000; k++) begin
      logic [31:0] r = $urandom;
      user_en = r[0]; user_ext_en = r[1]; user_evt_ro = r[2] & r[3];
      user_cyc_ro = r[4] & r[5]; user_mask = 6'(r[11:6]); user_mask_cyc = r[12];
      host_redirect = r[13]; l2_enabled = r[14]; l2_group_trap = r[15] & r[16];
      l2_pm_trap = r[17] & r[18]; l2_limit = 5'(r[21:19]); l3_pm_trap = r[22] & r[23];
      l3_undef_first = r[24];
      req(r[25], int'(r[27:26]), (r[30:28] == 7) ? 31 : int'(r[30:28]), $urandom);
      if (r[31] & r[29]) idle();
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule